// File: doc/BRIEF.md
# Cascaded Dual-Channel Capture Timer

This block joins two counter channels into one wide time base. The lower channel advances once for every clock in which counting is enabled. When the lower channel rolls over from all ones to zero, the upper channel advances by one. Together the two channels form a count twice as wide as either one. A synchronous clear sets both channels to zero.

Each channel has an asynchronous capture pin. The pin passes through a synchronizer and then an edge detector. The edge detector is set by a 4-bit edge-select field. When the selected edge is seen, the channel copies its own counter value into its capture register and sets a capture flag. Software clears the flag with a write-one-to-clear strobe.

Each channel also has a cross-enable bit. When it is set, an edge on the other channel's pin also loads this channel's capture register. The edge on the other pin is judged by the other channel's edge-select field. With the upper channel's cross-enable set, one edge on the lower pin captures both halves of the count in the same cycle. Software then reads a consistent wide timestamp.

Top module: `cct_top`

## Requirements
- R1: While `count_en` is 1 and `cnt_clear` is 0, `cnt_lo` increases by one on each clock and wraps from all ones to zero. `cnt_hi` increases by one only on the clock where `cnt_lo` wraps. While `count_en` is 0, both counters hold their values.
- R2: When `cnt_clear` is 1, both counters are zero after the next clock edge, whatever the value of `count_en`.
- R3: The 4-bit edge-select field is decoded as follows: 4'b1000 selects the rising edge, 4'b1001 the falling edge, and 4'b1010 or 4'b1011 both edges. Every other value, including 4'b0000, disables the trigger.
- R4: Take a pin that changes between two clock edges. The capture register and flag of its own channel update on the third rising edge after the change. The value loaded is the counter value as it stood after the second of those edges, before that cycle's increment.
- R5: When a channel's cross-enable bit is 1, a selected edge on the other channel's pin loads this channel's capture register with its own counter value. The same-cycle timing as R4 applies, and the edge is judged by the other channel's edge-select field. If both pins trigger in the same cycle, the register is loaded once with that cycle's count.
- R6: When a channel's cross-enable bit is 0, an edge on the other channel's pin leaves that channel's capture register and flag unchanged.
- R7: A load sets the channel's capture flag. A 1 on the flag-clear strobe clears the flag on the next edge. If a load and a clear happen in the same cycle, the flag stays set.
- R8: After reset, both counters, both capture registers and both flags read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| count_en | input | 1 | Global count enable |
| cnt_clear | input | 1 | Synchronous clear of both counters |
| pin_lo | input | 1 | Asynchronous capture pin, lower channel |
| pin_hi | input | 1 | Asynchronous capture pin, upper channel |
| edge_sel_lo | input | 4 | Edge-select field, lower channel |
| edge_sel_hi | input | 4 | Edge-select field, upper channel |
| xen_lo | input | 1 | Lower channel also captures on upper pin edges |
| xen_hi | input | 1 | Upper channel also captures on lower pin edges |
| flag_clr_lo | input | 1 | Write-one-to-clear strobe, lower flag |
| flag_clr_hi | input | 1 | Write-one-to-clear strobe, upper flag |
| cnt_lo | output | CNT_W | Lower counter value |
| cnt_hi | output | CNT_W | Upper counter value |
| cap_lo | output | CNT_W | Lower capture register |
| cap_hi | output | CNT_W | Upper capture register |
| cap_flag_lo | output | 1 | Lower capture event flag |
| cap_flag_hi | output | 1 | Upper capture event flag |

## Verification
The bench builds the block with `CNT_W` = 8 and the default two synchronizer stages. At that width the lower channel wraps every 256 cycles, so the bench can drive many wraps into the upper channel in a short run. It can also check the combined count against its own wide model across those wraps. The default synchronizer depth keeps the capture latency at the three-edge figure that the capture checks are timed against.

// File: rtl/cct_pkg.sv
package cct_pkg;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_mode_t;

    function automatic edge_mode_t decode_edge(input logic [3:0] sel);
        edge_mode_t m;
        m = '0;
        case (sel)
            4'b1000: m.rise = 1'b1;
            4'b1001: m.fall = 1'b1;
            4'b1010,
            4'b1011: begin
                m.rise = 1'b1;
                m.fall = 1'b1;
            end
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cct_pin_sync.sv
module cct_pin_sync
    import cct_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin,
    input  logic [3:0] sel,
    output logic       evt
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } state_t;

    state_t     st_d, st_q;
    edge_mode_t mode;
    logic       lvl;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pin};
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lvl  = st_q.sync[STAGES-1];
    assign mode = decode_edge(sel);
    assign evt  = (mode.rise & lvl & ~st_q.prev) | (mode.fall & ~lvl & st_q.prev);

    AST_NO_EVT_STEADY: assert property (@(posedge clk) disable iff (rst)
        (lvl == st_q.prev) |-> !evt) else $error("evt without level change"); // R3

    AST_NO_EVT_OFF: assert property (@(posedge clk) disable iff (rst)
        (sel[3] == 1'b0) |-> !evt) else $error("evt with trigger disabled"); // R3

endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clr,
    output logic [CNT_W-1:0] lo,
    output logic [CNT_W-1:0] hi
);

    typedef struct packed {
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
    } state_t;

    state_t st_d, st_q;
    logic   lo_full;

    assign lo_full = (st_q.lo == {CNT_W{1'b1}});

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (en) begin
            st_d.lo = st_q.lo + 1'b1;
            if (lo_full) st_d.hi = st_q.hi + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lo = st_q.lo;
    assign hi = st_q.hi;

    AST_HI_CARRY: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && lo == {CNT_W{1'b1}}) |=> (lo == '0 && hi == $past(hi) + 1'b1))
        else $error("missing carry"); // R1

    AST_HI_STILL: assert property (@(posedge clk) disable iff (rst)
        (!clr && !(en && lo == {CNT_W{1'b1}})) |=> $stable(hi))
        else $error("upper moved without wrap"); // R1

    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> (lo == '0 && hi == '0)) else $error("clear failed"); // R2

endmodule

// File: rtl/cct_capture.sv
module cct_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             own_evt,
    input  logic             other_evt,
    input  logic             xen,
    input  logic             flag_clr,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap,
    output logic             flag
);

    typedef struct packed {
        logic [CNT_W-1:0] cap;
        logic             flag;
    } state_t;

    state_t st_d, st_q;
    logic   load;

    assign load = own_evt | (xen & other_evt);

    always_comb begin
        st_d = st_q;
        if (flag_clr) st_d.flag = 1'b0;
        if (load) begin
            st_d.cap  = cnt;
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cap  = st_q.cap;
    assign flag = st_q.flag;

    AST_OWN_LOAD: assert property (@(posedge clk) disable iff (rst)
        own_evt |=> (cap == $past(cnt) && flag)) else $error("own load wrong"); // R4

    AST_NO_CROSS: assert property (@(posedge clk) disable iff (rst)
        (!own_evt && !xen) |=> $stable(cap)) else $error("capture without enable"); // R6

    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !own_evt && !other_evt) |=> !flag) else $error("flag not cleared"); // R7

endmodule

// File: rtl/cct_top.sv
module cct_top #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_en,
    input  logic             cnt_clear,
    input  logic             pin_lo,
    input  logic             pin_hi,
    input  logic [3:0]       edge_sel_lo,
    input  logic [3:0]       edge_sel_hi,
    input  logic             xen_lo,
    input  logic             xen_hi,
    input  logic             flag_clr_lo,
    input  logic             flag_clr_hi,
    output logic [CNT_W-1:0] cnt_lo,
    output logic [CNT_W-1:0] cnt_hi,
    output logic [CNT_W-1:0] cap_lo,
    output logic [CNT_W-1:0] cap_hi,
    output logic             cap_flag_lo,
    output logic             cap_flag_hi
);

    localparam int NCH = 2;

    logic [NCH-1:0]       pins;
    logic [3:0]           sels  [NCH];
    logic [NCH-1:0]       evts;
    logic [NCH-1:0]       xens;
    logic [NCH-1:0]       clrs;
    logic [CNT_W-1:0]     cnts  [NCH];
    logic [CNT_W-1:0]     caps  [NCH];
    logic [NCH-1:0]       flags;

    assign pins    = {pin_hi, pin_lo};
    assign sels[0] = edge_sel_lo;
    assign sels[1] = edge_sel_hi;
    assign xens    = {xen_hi, xen_lo};
    assign clrs    = {flag_clr_hi, flag_clr_lo};

    cct_counter #(.CNT_W(CNT_W)) i_counter (
        .clk (clk),
        .rst (rst),
        .en  (count_en),
        .clr (cnt_clear),
        .lo  (cnt_lo),
        .hi  (cnt_hi)
    );

    assign cnts[0] = cnt_lo;
    assign cnts[1] = cnt_hi;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        cct_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk (clk),
            .rst (rst),
            .pin (pins[c]),
            .sel (sels[c]),
            .evt (evts[c])
        );

        cct_capture #(.CNT_W(CNT_W)) i_cap (
            .clk       (clk),
            .rst       (rst),
            .own_evt   (evts[c]),
            .other_evt (evts[NCH-1-c]),
            .xen       (xens[c]),
            .flag_clr  (clrs[c]),
            .cnt       (cnts[c]),
            .cap       (caps[c]),
            .flag      (flags[c])
        );
    end

    assign cap_lo      = caps[0];
    assign cap_hi      = caps[1];
    assign cap_flag_lo = flags[0];
    assign cap_flag_hi = flags[1];

    AST_CROSS_HI: assert property (@(posedge clk) disable iff (rst)
        (xen_hi && evts[0]) |=> (cap_hi == $past(cnt_hi) && cap_flag_hi))
        else $error("cross load of upper channel wrong"); // R5

    AST_CROSS_LO: assert property (@(posedge clk) disable iff (rst)
        (xen_lo && evts[1]) |=> (cap_lo == $past(cnt_lo) && cap_flag_lo))
        else $error("cross load of lower channel wrong"); // R5

    AST_ISOLATE_LO: assert property (@(posedge clk) disable iff (rst)
        (!xen_lo && !evts[0] && !flag_clr_lo) |=> ($stable(cap_lo) && $stable(cap_flag_lo)))
        else $error("lower channel disturbed"); // R6

endmodule

// File: tb/test_cct_top.sv
module test_cct_top;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          count_en = 1'b0, cnt_clear = 1'b0;
    logic          pin_lo = 1'b0, pin_hi = 1'b0;
    logic [3:0]    edge_sel_lo = '0, edge_sel_hi = '0;
    logic          xen_lo = 1'b0, xen_hi = 1'b0;
    logic          flag_clr_lo = 1'b0, flag_clr_hi = 1'b0;
    logic [CW-1:0] cnt_lo, cnt_hi, cap_lo, cap_hi;
    logic          cap_flag_lo, cap_flag_hi;

    int n_chk = 0;
    int n_bad = 0;
    logic [2*CW-1:0] model = '0;

    always #2.5 clk = ~clk;

    cct_top #(.CNT_W(CW), .SYNC_STAGES(2)) i_cct_top (
        .clk(clk), .rst(rst), .count_en(count_en), .cnt_clear(cnt_clear),
        .pin_lo(pin_lo), .pin_hi(pin_hi),
        .edge_sel_lo(edge_sel_lo), .edge_sel_hi(edge_sel_hi),
        .xen_lo(xen_lo), .xen_hi(xen_hi),
        .flag_clr_lo(flag_clr_lo), .flag_clr_hi(flag_clr_hi),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cap_lo(cap_lo), .cap_hi(cap_hi),
        .cap_flag_lo(cap_flag_lo), .cap_flag_hi(cap_flag_hi)
    );

    // Wide reference count built from R1/R2
    always @(posedge clk) begin
        if (rst || cnt_clear) model <= '0;
        else if (count_en)    model <= model + 1'b1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flags();
        @(negedge clk);
        flag_clr_lo = 1'b1; flag_clr_hi = 1'b1;
        @(negedge clk);
        flag_clr_lo = 1'b0; flag_clr_hi = 1'b0;
    endtask

    // Drive pins at a falling edge; snapshot the count after the second
    // rising edge; return at the falling edge after the third (R4 timing).
    task automatic do_edge(input logic lo_lvl, input logic hi_lvl,
                           input logic clr_at_load, output logic [2*CW-1:0] snap);
        @(negedge clk);
        pin_lo = lo_lvl; pin_hi = hi_lvl;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        snap = model;
        if (clr_at_load) begin flag_clr_lo = 1'b1; flag_clr_hi = 1'b1; end
        @(posedge clk);
        @(negedge clk);
        flag_clr_lo = 1'b0; flag_clr_hi = 1'b0;
    endtask

    // {edge select, 1 = rising transition / 0 = falling, expect capture}
    localparam int NV = 12;
    localparam logic [5:0] VEC [NV] = '{
        {4'b1000, 1'b1, 1'b1}, {4'b1000, 1'b0, 1'b0},
        {4'b1001, 1'b0, 1'b1}, {4'b1001, 1'b1, 1'b0},
        {4'b1010, 1'b1, 1'b1}, {4'b1010, 1'b0, 1'b1},
        {4'b1011, 1'b0, 1'b1}, {4'b0000, 1'b1, 1'b0},
        {4'b0101, 1'b1, 1'b0}, {4'b1100, 1'b1, 1'b0},
        {4'b1111, 1'b0, 1'b0}, {4'b0001, 1'b0, 1'b0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [2*CW-1:0] snap;
        logic [CW-1:0]   hold_hi, hold_cap;

        step(4);
        rst = 1'b0;
        step(1);
        // R8 reset state
        chk("R8 counters", {cnt_hi, cnt_lo}, 0);
        chk("R8 captures", {cap_hi, cap_lo}, 0);
        chk("R8 flags", {cap_flag_hi, cap_flag_lo}, 0);
        step(5);
        chk("R1 hold while disabled", {cnt_hi, cnt_lo}, 0);

        count_en = 1'b1;
        step(600);
        chk("R1 combined count", {cnt_hi, cnt_lo}, model);

        // Locate the wrap of the lower channel
        for (int k = 0; k < 300 && cnt_lo != {CW{1'b1}}; k++) step(1);
        hold_hi = cnt_hi;
        step(1);
        chk("R1 lower wraps to zero", cnt_lo, 0);
        chk("R1 upper steps on wrap", cnt_hi, hold_hi + 1'b1);
        step(1);
        chk("R1 upper holds after wrap", cnt_hi, hold_hi + 1'b1);

        count_en = 1'b0;
        snap = model;
        step(4);
        chk("R1 hold mid-count", {cnt_hi, cnt_lo}, snap);
        count_en = 1'b1;

        cnt_clear = 1'b1;
        step(1);
        cnt_clear = 1'b0;
        chk("R2 clear while counting", {cnt_hi, cnt_lo}, 0);
        step(3);
        chk("R2 counting resumes", {cnt_hi, cnt_lo}, model);

        // R3/R4 edge-select table on the lower pin
        for (int i = 0; i < NV; i++) begin
            edge_sel_lo = 4'b0000;
            pin_lo = ~VEC[i][1];
            step(4);
            clear_flags();
            hold_cap = cap_lo;
            edge_sel_lo = VEC[i][5:2];
            do_edge(VEC[i][1], pin_hi, 1'b0, snap);
            chk($sformatf("R3 flag sel=%b rise=%0b", VEC[i][5:2], VEC[i][1]),
                cap_flag_lo, VEC[i][0]);
            chk("R4 capture value", cap_lo, VEC[i][0] ? snap[CW-1:0] : hold_cap);
            chk("R6 upper untouched", cap_flag_hi, 0);
        end
        edge_sel_lo = 4'b0000;
        pin_lo = 1'b0;
        step(4);

        // Upper channel own capture across many wraps
        step(700);
        clear_flags();
        edge_sel_hi = 4'b1000;
        do_edge(pin_lo, 1'b1, 1'b0, snap);
        chk("R4 upper own capture", cap_hi, snap[2*CW-1:CW]);
        chk("R6 lower not cross loaded", cap_flag_lo, 0);
        edge_sel_hi = 4'b0000;
        pin_hi = 1'b0;
        step(4);

        // R5 upper captures on lower pin, judged by lower's select
        clear_flags();
        xen_hi = 1'b1;
        edge_sel_lo = 4'b1001;
        edge_sel_hi = 4'b0000;
        pin_lo = 1'b1;
        step(4);
        clear_flags();
        do_edge(1'b0, pin_hi, 1'b0, snap);
        chk("R5 timestamp low half", cap_lo, snap[CW-1:0]);
        chk("R5 timestamp high half", cap_hi, snap[2*CW-1:CW]);
        chk("R5 upper flag", cap_flag_hi, 1);
        xen_hi = 1'b0;

        // R5 lower captures on upper pin
        edge_sel_lo = 4'b0000;
        edge_sel_hi = 4'b1000;
        xen_lo = 1'b1;
        step(4);
        clear_flags();
        do_edge(pin_lo, 1'b1, 1'b0, snap);
        chk("R5 lower cross capture", cap_lo, snap[CW-1:0]);
        chk("R5 lower cross flag", cap_flag_lo, 1);

        // R5 simultaneous triggers, both crossed
        xen_hi = 1'b1;
        edge_sel_lo = 4'b1000;
        edge_sel_hi = 4'b1001;
        step(4);
        clear_flags();
        do_edge(1'b1, 1'b0, 1'b0, snap);
        chk("R5 simultaneous lower", cap_lo, snap[CW-1:0]);
        chk("R5 simultaneous upper", cap_hi, snap[2*CW-1:CW]);
        chk("R5 simultaneous flags", {cap_flag_hi, cap_flag_lo}, 2'b11);

        // R7 set wins over clear, then clear alone
        xen_lo = 1'b0; xen_hi = 1'b0;
        edge_sel_hi = 4'b0000;
        edge_sel_lo = 4'b1001;
        do_edge(1'b0, pin_hi, 1'b1, snap);
        chk("R7 set wins over clear", cap_flag_lo, 1);
        chk("R7 clear without load", cap_flag_hi, 0);
        clear_flags();
        chk("R7 strobe clears flag", cap_flag_lo, 0);

        // R6 cross disabled: upper pin edge ignored by lower
        edge_sel_hi = 4'b1010;
        hold_cap = cap_lo;
        do_edge(pin_lo, 1'b1, 1'b0, snap);
        chk("R6 lower capture unchanged", cap_lo, hold_cap);
        chk("R6 lower flag unchanged", cap_flag_lo, 0);
        chk("R6 upper own still loads", cap_hi, snap[2*CW-1:CW]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule